// File: doc/BRIEF.md
# Interrupt Collector and Keyed Soft-Reset Registers

This block sits next to a serial peripheral controller. It collects seven single-cycle event pulses from that controller into one level-sensitive interrupt line. Each event sets a sticky status bit. Software clears a status bit by writing a one to it, so writing back a value it has just read acknowledges exactly the sources it saw. A per-source enable mask and a single master enable decide which pending sources reach the interrupt line.

The same register window also holds a keyed reset register. Only one specific key value written there starts a soft-reset pulse for the controller core. That pulse lasts a fixed number of cycles. While it is active, it also empties the status and per-source enable registers. Every other value written to that register is dropped.

The register bus is a plain 32-bit port: a write strobe, a byte address and write data. Read data is a combinational view of whichever register the address selects.

Top module: `irq_sr_block`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` and `soft_rst_o` are 0, and reads of offsets 0x1C, 0x20 and 0x28 return 0.
- R2: An event pulse on `evt_i[i]` sets status bit i (read at offset 0x20, bits 6:0) on the next clock edge, whatever the enable state. Bit 0 is mode fault, bit 1 is slave-mode fault, bit 2 is transmit FIFO empty, bit 3 is transmit underrun, bit 4 is receive FIFO full, bit 5 is receive overrun and bit 6 is transmit FIFO half empty.
- R3: A status bit stays set until a write to offset 0x20 carries a 1 in that bit position. Zeros in the write data leave status bits unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is 1 exactly when the master enable (bit 31 at offset 0x1C) is 1 and at least one bit is set in both the status register and the per-source enable register (offset 0x28, bits 6:0).
- R6: Bit 31 of offset 0x1C holds the master enable, and the other bits of that offset read 0. At offset 0x28, write-data bits above bit 6 are dropped and read back as 0.
- R7: A write of 0x0000000A to offset 0x40 drives `soft_rst_o` high for exactly RST_CYCLES consecutive cycles, starting in the cycle after the write.
- R8: A write of any other value to offset 0x40 leaves `soft_rst_o` low and changes no register.
- R9: A soft-reset pulse clears the status and per-source enable registers and drops events that arrive during it. The master enable keeps its value.
- R10: Reads of offset 0x40 or of any undefined offset return 0. Writes to undefined offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (8) | Byte offset of the register being read or written |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the register at `bus_addr` |
| evt_i | input | NUM_SRC (7) | Event pulses from the controller, one bit per source |
| irq_o | output | 1 | Interrupt request line |
| soft_rst_o | output | 1 | Reset pulse for the controller core |

## Verification
The bound checker watches the following on every cycle:
- every event pulse lands in its status bit;
- pending bits are sticky unless a clearing write or a soft reset is present;
- the interrupt line stays low without the master enable;
- undefined offsets read as zero;
- a rising reset pulse always follows a write of the correct key;
- status and enable registers stay empty while a reset pulse runs.

Only the bench's scenarios can show the rest:
- the exact length of the reset pulse;
- that a wrong key leaves every register untouched;
- that a set wins over a clear in the same cycle;
- that the master enable survives a soft reset.

// File: rtl/irq_sr_pkg.sv
// Package irq_sr_pkg
// Shared register offsets, the reset key and the decoded write-strobe type for
// the interrupt collector. Offsets are byte addresses on the register bus.
package irq_sr_pkg;
    localparam int unsigned OFF_GIE  = 32'h1C;
    localparam int unsigned OFF_ISR  = 32'h20;
    localparam int unsigned OFF_IER  = 32'h28;
    localparam int unsigned OFF_SRST = 32'h40;
    localparam int unsigned SRST_KEY = 32'h0000_000A;

    typedef struct packed {
        logic gie_wr;
        logic isr_wr;
        logic ier_wr;
        logic key_hit;
    } reg_strobe_t;
endpackage

// File: rtl/irq_sr_decode.sv
// Module irq_sr_decode
// Decodes bus writes into per-register strobes and checks the soft-reset key.
// Also builds the combinational read view. Assumes DATA_W > NUM_SRC and that
// the offsets fit in ADDR_W bits.
module irq_sr_decode
    import irq_sr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 7
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gie,
    input  logic [NUM_SRC-1:0] isr,
    input  logic [NUM_SRC-1:0] ier,
    output reg_strobe_t       strobe,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
    localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFF_ISR);
    localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);
    localparam logic [DATA_W-1:0] KEY    = DATA_W'(SRST_KEY);
    localparam int PAD_W = DATA_W - NUM_SRC;

    // Write strobe decode, including the full-word key comparison
    always_comb begin
        strobe.gie_wr  = wr_en && (addr == A_GIE);
        strobe.isr_wr  = wr_en && (addr == A_ISR);
        strobe.ier_wr  = wr_en && (addr == A_IER);
        strobe.key_hit = wr_en && (addr == A_SRST) && (wdata == KEY);
    end

    // Read mux; reset register and unknown offsets read as zero
    always_comb begin
        case (addr)
            A_GIE:   rdata = {gie, {(DATA_W-1){1'b0}}};
            A_ISR:   rdata = {{PAD_W{1'b0}}, isr};
            A_IER:   rdata = {{PAD_W{1'b0}}, ier};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_sr_enables.sv
// Module irq_sr_enables
// Holds the master interrupt enable and the per-source enable mask. The soft
// reset clears the mask only; the master enable survives it.
module irq_sr_enables #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               gie_wr,
    input  logic               gie_d,
    input  logic               ier_wr,
    input  logic [NUM_SRC-1:0] ier_d,
    output logic               gie,
    output logic [NUM_SRC-1:0] ier
);
    // Master enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      gie <= 1'b0;
        else if (gie_wr) gie <= gie_d;
    end

    // Per-source enable mask; a soft reset empties it
    always_ff @(posedge clk) begin
        if (!rst_n)      ier <= '0;
        else if (clr)    ier <= '0;
        else if (ier_wr) ier <= ier_d;
    end
endmodule

// File: rtl/irq_sr_status.sv
// Module irq_sr_status
// One sticky status bit per event source. Priority per bit: soft-reset clear,
// then event set, then write-one-to-clear. So a set beats a clear in the same
// cycle.
module irq_sr_status #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               w1c_wr,
    input  logic [NUM_SRC-1:0] w1c_mask,
    output logic [NUM_SRC-1:0] isr
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Latch event i, release it on a one written to its position
        always_ff @(posedge clk) begin
            if (!rst_n)                       isr[i] <= 1'b0;
            else if (clr)                     isr[i] <= 1'b0;
            else if (evt[i])                  isr[i] <= 1'b1;
            else if (w1c_wr && w1c_mask[i])   isr[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_sr_softrst.sv
// Module irq_sr_softrst
// Turns a key hit into a reset pulse RST_CYCLES long, starting the next cycle.
// A key hit during a running pulse reloads the count.
module irq_sr_softrst #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    output logic srst
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter holding the remaining pulse length
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (key_hit)      cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Pulse is high while cycles remain
    always_comb srst = (cnt_q != '0);
endmodule

// File: rtl/irq_sr_block.sv
// Module irq_sr_block (top)
// Interrupt collector and keyed soft-reset register block for a serial
// controller. Assumes event pulses are synchronous to clk.
module irq_sr_block
    import irq_sr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_SRC    = 7,
    parameter int RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               irq_o,
    output logic               soft_rst_o
);
    reg_strobe_t        strobe;
    logic               gie_q;
    logic [NUM_SRC-1:0] isr_q;
    logic [NUM_SRC-1:0] ier_q;

    irq_sr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_decode (
        .wr_en  (bus_wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .gie    (gie_q),
        .isr    (isr_q),
        .ier    (ier_q),
        .strobe (strobe),
        .rdata  (bus_rdata)
    );

    irq_sr_softrst #(.RST_CYCLES(RST_CYCLES)) u_softrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_hit (strobe.key_hit),
        .srst    (soft_rst_o)
    );

    irq_sr_enables #(.NUM_SRC(NUM_SRC)) u_enables (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst_o),
        .gie_wr (strobe.gie_wr),
        .gie_d  (bus_wdata[DATA_W-1]),
        .ier_wr (strobe.ier_wr),
        .ier_d  (bus_wdata[NUM_SRC-1:0]),
        .gie    (gie_q),
        .ier    (ier_q)
    );

    irq_sr_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst_o),
        .evt      (evt_i),
        .w1c_wr   (strobe.isr_wr),
        .w1c_mask (bus_wdata[NUM_SRC-1:0]),
        .isr      (isr_q)
    );

    // Interrupt line: master enable gating any enabled pending source
    always_comb irq_o = gie_q && |(isr_q & ier_q);
endmodule

// File: rtl/irq_sr_block_chk.sv
// Module irq_sr_block_chk
// Cycle-by-cycle properties for irq_sr_block, attached by bind.
module irq_sr_block_chk
    import irq_sr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               irq_o,
    input logic               soft_rst_o,
    input logic               gie_q,
    input logic [NUM_SRC-1:0] isr_q,
    input logic [NUM_SRC-1:0] ier_q
);
    logic key_wr, bad_key_wr, isr_wr, known_addr;

    // Port-level view of bus activity, decoded independently of the design
    always_comb begin
        key_wr     = bus_wr_en && bus_addr == ADDR_W'(OFF_SRST) && bus_wdata == DATA_W'(SRST_KEY);
        bad_key_wr = bus_wr_en && bus_addr == ADDR_W'(OFF_SRST) && bus_wdata != DATA_W'(SRST_KEY);
        isr_wr     = bus_wr_en && bus_addr == ADDR_W'(OFF_ISR);
        known_addr = bus_addr == ADDR_W'(OFF_GIE) || bus_addr == ADDR_W'(OFF_ISR) ||
                     bus_addr == ADDR_W'(OFF_IER);
    end

    p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0 && !soft_rst_o) |=> ((isr_q & $past(evt_i)) == $past(evt_i)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_o && !isr_wr) |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

    p_irq_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq_o);

    p_irq_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((isr_q & ier_q) != '0));

    p_srst_key_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_o) |-> $past(key_wr));

    p_bad_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_key_wr && !soft_rst_o) |=> !soft_rst_o);

    p_srst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o && $past(soft_rst_o)) |-> (isr_q == '0 && ier_q == '0));

    p_undef_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known_addr |-> bus_rdata == '0);
endmodule

bind irq_sr_block irq_sr_block_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_i      (evt_i),
    .irq_o      (irq_o),
    .soft_rst_o (soft_rst_o),
    .gie_q      (gie_q),
    .isr_q      (isr_q),
    .ier_q      (ier_q)
);

// File: tb/irq_sr_block_tb.sv
`timescale 1ns/1ps
module irq_sr_block_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NUM_SRC = 7;
    localparam int RST_CYCLES = 4;
    localparam int NSTEP = 15;

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [6:0]  evt;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    // Each step: one write and/or event pulse, then a read with expected results
    localparam vec_t VEC [NSTEP] = '{
        '{1'b1, 8'h28, 32'h0000_0005, 7'h00, 8'h28, 32'h0000_0005, 1'b0, 8'd6},  // R6 mask write
        '{1'b0, 8'h00, 32'h0,         7'h04, 8'h20, 32'h0000_0004, 1'b0, 8'd2},  // R2 latch, gie off
        '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 8'h1C, 32'h8000_0000, 1'b1, 8'd5},  // R5 gie on
        '{1'b0, 8'h00, 32'h0,         7'h12, 8'h20, 32'h0000_0016, 1'b1, 8'd2},  // R2 masked sources
        '{1'b1, 8'h20, 32'h0000_0004, 7'h00, 8'h20, 32'h0000_0012, 1'b0, 8'd3},  // R3 clear one
        '{1'b1, 8'h28, 32'h0000_0010, 7'h00, 8'h28, 32'h0000_0010, 1'b1, 8'd5},  // R5 new mask
        '{1'b1, 8'h20, 32'h0000_0000, 7'h00, 8'h20, 32'h0000_0012, 1'b1, 8'd3},  // R3 zeros ignored
        '{1'b1, 8'h20, 32'h0000_0010, 7'h10, 8'h20, 32'h0000_0012, 1'b1, 8'd4},  // R4 set wins
        '{1'b1, 8'h1C, 32'h7FFF_FFFF, 7'h00, 8'h1C, 32'h0000_0000, 1'b0, 8'd6},  // R6 gie off
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 7'h00, 8'h24, 32'h0000_0000, 1'b0, 8'd10}, // R10 undefined
        '{1'b1, 8'h40, 32'h0000_000B, 7'h00, 8'h20, 32'h0000_0012, 1'b0, 8'd8},  // R8 bad key
        '{1'b1, 8'h1C, 32'h8000_0000, 7'h00, 8'h20, 32'h0000_0012, 1'b1, 8'd5},  // R5 gie back
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 7'h00, 8'h20, 32'h0000_0000, 1'b0, 8'd3},  // R3 clear all
        '{1'b0, 8'h00, 32'h0,         7'h7F, 8'h20, 32'h0000_007F, 1'b1, 8'd2},  // R2 all sources
        '{1'b1, 8'h28, 32'hFFFF_FF80, 7'h00, 8'h28, 32'h0000_0000, 1'b0, 8'd6}   // R6 upper bits dropped
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_SRC-1:0] evt_i = '0;
    logic              irq_o;
    logic              soft_rst_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_sr_block #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
                   .RST_CYCLES(RST_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .soft_rst_o(soft_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write/event cycle, then present a read address and sample
    task automatic cycle_op(input logic wr, input logic [7:0] wa, input logic [31:0] wd,
                            input logic [6:0] ev, input logic [7:0] ra);
        @(negedge clk);
        bus_wr_en = wr; bus_addr = wa; bus_wdata = wd; evt_i = ev;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0; evt_i = '0; bus_addr = ra;
        #1;
    endtask

    task automatic read_at(input logic [7:0] ra);
        @(negedge clk);
        bus_addr = ra;
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_at(8'h1C); check("R1 gie", bus_rdata, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 srst", {31'b0, soft_rst_o}, 32'h0);
        read_at(8'h20); check("R1 isr", bus_rdata, 32'h0);
        read_at(8'h28); check("R1 ier", bus_rdata, 32'h0);

        // Table walk (R2 R3 R4 R5 R6 R8 R10)
        for (int i = 0; i < NSTEP; i++) begin
            cycle_op(VEC[i].wr, VEC[i].waddr, VEC[i].wdata, VEC[i].evt, VEC[i].raddr);
            check($sformatf("R%0d step %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp_rd);
            check($sformatf("R%0d step %0d irq", VEC[i].req, i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
            check($sformatf("R8 step %0d srst idle", i), {31'b0, soft_rst_o}, 32'h0);
        end

        // R10: reset register itself reads as zero
        read_at(8'h40); check("R10 srst reg read", bus_rdata, 32'h0);

        // R7 R9: arm a pending enabled source, then fire the key
        cycle_op(1'b1, 8'h28, 32'h0000_007F, 7'h00, 8'h28);
        check("R5 irq before srst", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h0000_000A;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0; bus_addr = 8'h20;
        evt_i = 7'h7F;  // R9: events during the pulse are dropped
        #1;
        begin
            int width = 0;
            while (soft_rst_o && width < 20) begin
                width++;
                @(negedge clk);
                evt_i = '0;
                #1;
            end
            check("R7 pulse width", width, RST_CYCLES);
        end
        check("R9 isr cleared", bus_rdata, 32'h0);
        read_at(8'h28); check("R9 ier cleared", bus_rdata, 32'h0);
        read_at(8'h1C); check("R9 gie kept", bus_rdata, 32'h8000_0000);
        check("R9 irq low", {31'b0, irq_o}, 32'h0);

        // R7: the pulse does not repeat on its own
        repeat (3) @(negedge clk);
        #1; check("R7 pulse ended", {31'b0, soft_rst_o}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule